// File: doc/BRIEF.md
# Fetch Block Pre-decoder with Twin Start Chains

This block sits in the instruction fetch path of a RISC-V core and looks at one fetch block's worth of raw bytes before the real decoder does. It takes seventeen 16-bit halfwords. From them it builds sixteen overlapping 32-bit windows, one starting at each halfword, so slot i sees halfwords i and i+1. For every slot it reports a short summary:
- whether the parcel is compressed;
- whether it is a control-flow instruction, and of which kind;
- whether it links (a call) or returns;
- the signed displacement the target adder will need.

Which slots actually begin an instruction depends on where the previous block ended. The block therefore computes two start-of-instruction chains side by side. The aligned chain assumes halfword 0 opens an instruction. The shifted chain assumes halfword 0 is the second half of a 32-bit instruction that began in the previous line. The fetch unit picks one of the two once it knows whether such a straddling instruction exists. Everything is combinational, so the results follow the input within the same cycle.

Top module: `fetch_predecoder`

## Requirements
- R1: Slot i (0..15) decodes the 32-bit word formed by halfword i in bits [15:0] and halfword i+1 in bits [31:16], so slot 15 draws its upper half from halfword 16.
- R2: `slot_rvc[i]` is 1 exactly when bits [1:0] of halfword i differ from binary 11.
- R3: In `start_aligned`, bit 0 is 1. For n of 1 or more, bit n is 1 when bit n-1 is 0, or when bit n-1 is 1 and slot n-1 is compressed. No two adjacent bits are both 0.
- R4: In `start_shifted`, bit 0 is 0 and bit 1 is 1. From n = 2 upward it follows the same rule as R3.
- R5: For 32-bit parcels, `slot_kind` (2 bits per slot, slot i at bits [2i+1:2i]) is:
  - 01 for opcode 1100011 (conditional branch);
  - 10 for opcode 1101111 (jal);
  - 11 for opcode 1100111 (jalr);
  - 00 otherwise.
- R6: Compressed parcels are classified as follows:
  - quadrant 01 with funct3 101 gives kind 10;
  - quadrant 01 with funct3 110 or 111 gives kind 01;
  - quadrant 10 with funct3 100, bits [11:7] nonzero and bits [6:2] zero gives kind 11, whatever bit 12 is;
  - every other compressed parcel gives kind 00.
- R7: `slot_call` is 1 for a kind 10 or 11 slot whose destination register is x1 or x5. For a 32-bit parcel the destination is bits [11:7]. The compressed jump-to-register with bit 12 set links to x1, and the compressed jump links nothing.
- R8: `slot_ret` is 1 for a kind 11 slot whose source register is x1 or x5 and whose destination is not x1 or x5. For a 32-bit parcel the source is bits [19:15]; for a compressed parcel it is bits [11:7].
- R9: For 32-bit branches `slot_off` holds the sign-extended branch displacement, and for 32-bit jal the sign-extended jump displacement. Each is 21 bits per slot, slot i at bits [21i+20:21i].
- R10: For compressed branches and compressed jumps `slot_off` holds their sign-extended displacements.
- R11: `slot_off` is zero for kind 00 and kind 11 slots, and `slot_cfi[i]` is 1 exactly when the slot's kind is not 00.
- R12: All outputs depend only on the current `fetch_hw`, with no storage, so they are valid in the cycle the input is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_hw | input | 272 | Seventeen halfwords, halfword k at bits [16k+15:16k] |
| slot_rvc | output | 16 | Per-slot compressed flag |
| slot_cfi | output | 16 | Per-slot control-flow flag |
| slot_call | output | 16 | Per-slot call flag |
| slot_ret | output | 16 | Per-slot return flag |
| slot_kind | output | 32 | Per-slot 2-bit control-flow kind |
| slot_off | output | 336 | Per-slot 21-bit signed target displacement |
| start_aligned | output | 16 | Start vector assuming halfword 0 opens an instruction |
| start_shifted | output | 16 | Start vector assuming halfword 0 closes a straddling instruction |

## Verification
The block holds no state, so a faulty link in a start chain shows up at once, in the same cycle, as a shifted run of ones in one of the two vectors. That error repeats in every later slot of the block, so walking random mixes of compressed and full-width parcels exposes it quickly. A wrong bit in a displacement gather or a misread register field appears only in the affected slot. For that reason, every control-flow form is placed with a known displacement near its sign and range limits, and both link registers are used as destination and as source.

// File: rtl/predec_pkg.sv
package predec_pkg;

  localparam int unsigned PD_IMM_W = 21;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'b00,
    KIND_BRANCH = 2'b01,
    KIND_JAL    = 2'b10,
    KIND_JALR   = 2'b11
  } cf_kind_e;

  function automatic logic parcel_is_short(input logic [1:0] low);
    return low != 2'b11;
  endfunction

  function automatic logic is_link_reg(input logic [4:0] r);
    return (r == 5'd1) || (r == 5'd5);
  endfunction

  // 32-bit conditional branch displacement
  function automatic logic [PD_IMM_W-1:0] disp_branch32(input logic [31:0] w);
    return {{8{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  // 32-bit jal displacement
  function automatic logic [PD_IMM_W-1:0] disp_jump32(input logic [31:0] w);
    return {w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  // compressed branch displacement
  function automatic logic [PD_IMM_W-1:0] disp_branch16(input logic [15:0] c);
    return {{12{c[12]}}, c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
  endfunction

  // compressed jump displacement
  function automatic logic [PD_IMM_W-1:0] disp_jump16(input logic [15:0] c);
    return {{9{c[12]}}, c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  endfunction

endpackage

// File: rtl/predec_window.sv
module predec_window #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned HW_W  = 16,
  localparam int unsigned NHW  = SLOTS + 1,
  localparam int unsigned WIN_W = 2 * HW_W
) (
  input  logic [NHW*HW_W-1:0]        raw,
  output logic [SLOTS-1:0][WIN_W-1:0] win
);
  // each slot sees its own halfword below and the next one above (R1)
  for (genvar i = 0; i < SLOTS; i++) begin : g_win
    assign win[i] = {raw[(i+1)*HW_W +: HW_W], raw[i*HW_W +: HW_W]};
  end
endmodule

// File: rtl/predec_slot.sv
module predec_slot
  import predec_pkg::*;
#(
  parameter int unsigned OFF_W = 21
) (
  input  logic [31:0]      win,
  output logic             rvc,
  output cf_kind_e         kind,
  output logic             call,
  output logic             ret,
  output logic [OFF_W-1:0] off
);
  logic [15:0] lo;
  logic [1:0]  quad;
  logic [2:0]  cf3;
  logic [6:0]  opc;
  logic [4:0]  rd32, rs1_32, crs1;

  // named decode events, visible to the assertions
  logic ev_br32, ev_jal32, ev_jalr32;
  logic ev_cj, ev_cb, ev_cjr_any, ev_cjalr;
  logic [PD_IMM_W-1:0] imm_raw;
  logic [4:0] dst_reg, src_reg;

  assign lo     = win[15:0];
  assign quad   = win[1:0];
  assign cf3    = win[15:13];
  assign opc    = win[6:0];
  assign rd32   = win[11:7];
  assign rs1_32 = win[19:15];
  assign crs1   = win[11:7];

  assign rvc = parcel_is_short(quad);

  assign ev_br32   = !rvc && (opc == 7'b1100011);
  assign ev_jal32  = !rvc && (opc == 7'b1101111);
  assign ev_jalr32 = !rvc && (opc == 7'b1100111);

  assign ev_cj      = (quad == 2'b01) && (cf3 == 3'b101);
  assign ev_cb      = (quad == 2'b01) && (cf3[2:1] == 2'b11);
  assign ev_cjr_any = (quad == 2'b10) && (cf3 == 3'b100)
                      && (crs1 != 5'd0) && (win[6:2] == 5'd0);
  assign ev_cjalr   = ev_cjr_any && win[12];

  always_comb begin
    kind = KIND_NONE;
    if (ev_br32 || ev_cb)              kind = KIND_BRANCH;
    else if (ev_jal32 || ev_cj)        kind = KIND_JAL;
    else if (ev_jalr32 || ev_cjr_any)  kind = KIND_JALR;
  end

  // effective destination and source registers
  always_comb begin
    dst_reg = 5'd0;
    src_reg = 5'd0;
    if (ev_jal32 || ev_jalr32) begin
      dst_reg = rd32;
      src_reg = rs1_32;
    end else if (ev_cjr_any) begin
      dst_reg = ev_cjalr ? 5'd1 : 5'd0;
      src_reg = crs1;
    end
  end

  assign call = ((kind == KIND_JAL) || (kind == KIND_JALR)) && is_link_reg(dst_reg);
  assign ret  = (kind == KIND_JALR) && is_link_reg(src_reg) && !is_link_reg(dst_reg);

  always_comb begin
    imm_raw = '0;
    if (ev_br32)       imm_raw = disp_branch32(win);
    else if (ev_jal32) imm_raw = disp_jump32(win);
    else if (ev_cb)    imm_raw = disp_branch16(lo);
    else if (ev_cj)    imm_raw = disp_jump16(lo);
  end

  assign off = OFF_W'($signed(imm_raw));
endmodule

// File: rtl/predec_start_chain.sv
module predec_start_chain #(
  parameter int unsigned SLOTS      = 16,
  parameter bit          SKIP_FIRST = 1'b0
) (
  input  logic [SLOTS-1:0] rvc,
  output logic [SLOTS-1:0] starts
);
  localparam int unsigned FIRST_LINKED = SKIP_FIRST ? 2 : 1;

  if (SKIP_FIRST) begin : g_shift
    assign starts[0] = 1'b0;
    assign starts[1] = 1'b1;
  end else begin : g_align
    assign starts[0] = 1'b1;
  end

  // a slot opens an instruction when the previous one was a short start
  // or was the tail of a long one
  for (genvar n = FIRST_LINKED; n < SLOTS; n++) begin : g_link
    assign starts[n] = !starts[n-1] || rvc[n-1];
  end
endmodule

// File: rtl/fetch_predecoder.sv
module fetch_predecoder
  import predec_pkg::*;
#(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned HW_W  = 16,
  parameter int unsigned OFF_W = 21,
  localparam int unsigned NHW  = SLOTS + 1,
  localparam int unsigned WIN_W = 2 * HW_W
) (
  input  logic [NHW*HW_W-1:0]  fetch_hw,
  output logic [SLOTS-1:0]     slot_rvc,
  output logic [SLOTS-1:0]     slot_cfi,
  output logic [SLOTS-1:0]     slot_call,
  output logic [SLOTS-1:0]     slot_ret,
  output logic [2*SLOTS-1:0]   slot_kind,
  output logic [SLOTS*OFF_W-1:0] slot_off,
  output logic [SLOTS-1:0]     start_aligned,
  output logic [SLOTS-1:0]     start_shifted
);
  logic [SLOTS-1:0][WIN_W-1:0] win;
  cf_kind_e                    kind_arr [SLOTS];

  predec_window #(.SLOTS(SLOTS), .HW_W(HW_W)) u_win (
    .raw (fetch_hw),
    .win (win)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    predec_slot #(.OFF_W(OFF_W)) u_slot (
      .win  (win[i][31:0]),
      .rvc  (slot_rvc[i]),
      .kind (kind_arr[i]),
      .call (slot_call[i]),
      .ret  (slot_ret[i]),
      .off  (slot_off[i*OFF_W +: OFF_W])
    );
    assign slot_kind[2*i +: 2] = kind_arr[i];
    assign slot_cfi[i]         = kind_arr[i] != KIND_NONE;
  end

  predec_start_chain #(.SLOTS(SLOTS), .SKIP_FIRST(1'b0)) u_chain_aligned (
    .rvc    (slot_rvc),
    .starts (start_aligned)
  );

  predec_start_chain #(.SLOTS(SLOTS), .SKIP_FIRST(1'b1)) u_chain_shifted (
    .rvc    (slot_rvc),
    .starts (start_shifted)
  );
endmodule

// File: rtl/predec_checker.sv
module predec_checker #(
  parameter int unsigned SLOTS = 16,
  parameter int unsigned OFF_W = 21
) (
  input logic [SLOTS-1:0]       rvc,
  input logic [SLOTS-1:0]       cfi,
  input logic [SLOTS-1:0]       call,
  input logic [SLOTS-1:0]       ret,
  input logic [2*SLOTS-1:0]     kind,
  input logic [SLOTS*OFF_W-1:0] off,
  input logic [SLOTS-1:0]       s_al,
  input logic [SLOTS-1:0]       s_sh
);
  always_comb begin
    assert_aligned_head_R3: assert (s_al[0])
      else $error("aligned chain does not open at slot 0");
    assert_shifted_head_R4: assert (!s_sh[0] && s_sh[1])
      else $error("shifted chain head wrong");
    for (int i = 0; i < SLOTS; i++) begin
      assert_call_is_jump_R7: assert (!call[i] || kind[2*i+1])
        else $error("call on non-jump slot %0d", i);
      assert_ret_is_jalr_R8: assert (!ret[i] || (kind[2*i +: 2] == 2'b11 && !call[i]))
        else $error("bad ret on slot %0d", i);
      assert_cfi_kind_R11: assert (cfi[i] == (kind[2*i +: 2] != 2'b00))
        else $error("cfi flag disagrees with kind on slot %0d", i);
      assert_zero_off_R11: assert (kind[2*i] != kind[2*i+1] || off[i*OFF_W +: OFF_W] == '0)
        else $error("nonzero offset on slot %0d", i);
    end
    for (int n = 1; n < SLOTS; n++) begin
      assert_no_gap_aligned_R3: assert (s_al[n-1] || s_al[n])
        else $error("two non-starts at %0d", n);
      assert_no_gap_shifted_R4: assert (s_sh[n-1] || s_sh[n])
        else $error("two non-starts at %0d", n);
      assert_short_next_R2: assert (!(s_al[n-1] && rvc[n-1]) || s_al[n])
        else $error("short start not followed by start at %0d", n);
    end
  end
endmodule

bind fetch_predecoder predec_checker #(.SLOTS(SLOTS), .OFF_W(OFF_W)) u_chk (
  .rvc  (slot_rvc),
  .cfi  (slot_cfi),
  .call (slot_call),
  .ret  (slot_ret),
  .kind (slot_kind),
  .off  (slot_off),
  .s_al (start_aligned),
  .s_sh (start_shifted)
);

// File: tb/fetch_predecoder_test.sv
module fetch_predecoder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [17*16-1:0] fetch_hw = '0;
  logic [15:0] slot_rvc, slot_cfi, slot_call, slot_ret, start_aligned, start_shifted;
  logic [31:0] slot_kind;
  logic [16*21-1:0] slot_off;

  fetch_predecoder uut (
    .fetch_hw(fetch_hw), .slot_rvc(slot_rvc), .slot_cfi(slot_cfi),
    .slot_call(slot_call), .slot_ret(slot_ret), .slot_kind(slot_kind),
    .slot_off(slot_off), .start_aligned(start_aligned), .start_shifted(start_shifted)
  );

  typedef struct packed {
    logic [15:0]      care, rvc, sa, ss, call, ret;
    logic [31:0]      kind;
    logic [16*21-1:0] off;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  logic [15:0] hw [17];
  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // encoders: build instructions from a chosen displacement
  function automatic logic [31:0] e_jal(input logic [4:0] rd, input logic [20:0] d);
    logic [31:0] w = 32'h0000006f;
    w[31] = d[20]; w[30:21] = d[10:1]; w[20] = d[11]; w[19:12] = d[19:12]; w[11:7] = rd;
    return w;
  endfunction
  function automatic logic [31:0] e_br(input logic [2:0] f3, input logic [20:0] d);
    logic [31:0] w = 32'h00000063;
    w[31] = d[12]; w[30:25] = d[10:5]; w[24:20] = 5'd3; w[19:15] = 5'd4;
    w[14:12] = f3; w[11:8] = d[4:1]; w[7] = d[11];
    return w;
  endfunction
  function automatic logic [31:0] e_jalr(input logic [4:0] rd, input logic [4:0] rs1);
    return {12'h010, rs1, 3'b000, rd, 7'b1100111};
  endfunction
  function automatic logic [15:0] e_cj(input logic [20:0] d);
    logic [15:0] c = 16'ha001;
    c[12] = d[11]; c[11] = d[4]; c[10:9] = d[9:8]; c[8] = d[10];
    c[7] = d[6]; c[6] = d[7]; c[5:3] = d[3:1]; c[2] = d[5];
    return c;
  endfunction
  function automatic logic [15:0] e_cb(input logic [2:0] f3, input logic [20:0] d);
    logic [15:0] c = 16'h0001;
    c[15:13] = f3; c[12] = d[8]; c[11:10] = d[4:3]; c[9:7] = 3'd2;
    c[6:5] = d[7:6]; c[4:3] = d[2:1]; c[2] = d[5];
    return c;
  endfunction
  function automatic logic [15:0] e_cjr(input logic [4:0] rs1, input bit lnk);
    return {3'b100, lnk, rs1, 5'd0, 2'b10};
  endfunction

  function automatic logic [15:0] walk(input logic [15:0] rv, input int first);
    logic [15:0] v = '0;
    int p = first;
    while (p < 16) begin
      v[p] = 1'b1;
      p += rv[p] ? 1 : 2;
    end
    return v;
  endfunction

  task automatic open_block(input logic [15:0] fill);
    cur = '0;
    for (int k = 0; k < 17; k++) hw[k] = fill;
  endtask

  task automatic expect_slot(input int s, input logic [1:0] k, input bit c, input bit r, input logic [20:0] d);
    cur.care[s] = 1'b1;
    cur.kind[2*s +: 2] = k;
    cur.call[s] = c;
    cur.ret[s] = r;
    cur.off[s*21 +: 21] = d;
  endtask

  task automatic put32(input int s, input logic [31:0] w, input logic [1:0] k, input bit c, input bit r, input logic [20:0] d);
    hw[s] = w[15:0];
    hw[s+1] = w[31:16];
    expect_slot(s, k, c, r, d);
  endtask

  task automatic put16(input int s, input logic [15:0] w, input logic [1:0] k, input bit c, input bit r, input logic [20:0] d);
    hw[s] = w;
    expect_slot(s, k, c, r, d);
  endtask

  // driver: push the expected item, apply the block at the next edge
  task automatic send();
    for (int k = 0; k < 16; k++) cur.rvc[k] = (hw[k][1:0] != 2'b11);
    cur.sa = walk(cur.rvc, 0);
    cur.ss = walk(cur.rvc, 1);
    @(posedge clk);
    for (int k = 0; k < 17; k++) fetch_hw[k*16 +: 16] <= hw[k];
    q.push_back(cur);
  endtask

  // monitor: results are combinational (R12), compared half a cycle later
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(slot_rvc == e.rvc, "R2", 64'(slot_rvc), 64'(e.rvc));
      chk(start_aligned == e.sa, "R3", 64'(start_aligned), 64'(e.sa));
      chk(start_shifted == e.ss, "R4", 64'(start_shifted), 64'(e.ss));
      for (int s = 0; s < 16; s++) begin
        if (e.care[s]) begin
          logic [1:0]  ek;
          logic [20:0] eo;
          ek = e.kind[2*s +: 2];
          eo = e.off[s*21 +: 21];
          chk(slot_kind[2*s +: 2] == ek, e.rvc[s] ? "R6 kind" : "R5 kind",
              64'(slot_kind[2*s +: 2]), 64'(ek));
          chk(slot_cfi[s] == (ek != 2'b00), "R11 cfi", 64'(slot_cfi[s]), 64'(ek != 2'b00));
          chk(slot_call[s] == e.call[s], "R7 call", 64'(slot_call[s]), 64'(e.call[s]));
          chk(slot_ret[s] == e.ret[s], "R8 ret", 64'(slot_ret[s]), 64'(e.ret[s]));
          chk(slot_off[s*21 +: 21] == eo,
              (ek == 2'b00 || ek == 2'b11) ? "R11 off" : (e.rvc[s] ? "R10 off" : "R9 off"),
              64'(slot_off[s*21 +: 21]), 64'(eo));
        end
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1badcafe;

    // initial state: all-zero input, every slot short and not a jump
    open_block(16'h0000);
    put16(0, 16'h0000, 2'b00, 0, 0, 21'd0);
    send();

    // all 32-bit nops: alternating long starts
    open_block(16'h0000);
    for (int s = 0; s < 16; s += 2) put32(s, 32'h00000013, 2'b00, 0, 0, 21'd0);
    send();

    // 32-bit control flow forms (R5, R7, R8, R9); slot 15 reaches halfword 16 (R1)
    open_block(16'h0001);
    put32(0,  e_jal(5'd1, 21'h000800), 2'b10, 1, 0, 21'h000800);
    put32(2,  e_br(3'b000, -21'sd8), 2'b01, 0, 0, -21'sd8);
    put32(4,  e_jalr(5'd0, 5'd1), 2'b11, 0, 1, 21'd0);
    put32(6,  e_jalr(5'd1, 5'd5), 2'b11, 1, 0, 21'd0);
    put32(8,  e_jal(5'd0, 21'h100000), 2'b10, 0, 0, 21'h100000);
    put32(10, e_br(3'b101, 21'd4094), 2'b01, 0, 0, 21'd4094);
    put32(12, 32'h00000013, 2'b00, 0, 0, 21'd0);
    put16(14, 16'h0001, 2'b00, 0, 0, 21'd0);
    put32(15, e_jal(5'd5, 21'h0007fe), 2'b10, 1, 0, 21'h0007fe);
    send();

    // compressed forms (R6, R7, R8, R10)
    open_block(16'h0001);
    put16(0, e_cj(-21'sd2), 2'b10, 0, 0, -21'sd2);
    put16(1, e_cb(3'b110, 21'h0fe), 2'b01, 0, 0, 21'h0fe);
    put16(2, e_cb(3'b111, -21'sd256), 2'b01, 0, 0, -21'sd256);
    put16(3, e_cjr(5'd1, 1'b0), 2'b11, 0, 1, 21'd0);
    put16(4, e_cjr(5'd5, 1'b1), 2'b11, 1, 0, 21'd0);
    put16(5, e_cjr(5'd7, 1'b0), 2'b11, 0, 0, 21'd0);
    put16(6, e_cj(21'd2046), 2'b10, 0, 0, 21'd2046);
    put32(7, e_jal(5'd0, 21'd4), 2'b10, 0, 0, 21'd4);
    put16(9, e_cj(-21'sd2048), 2'b10, 0, 0, -21'sd2048);
    put16(10, 16'h0001, 2'b00, 0, 0, 21'd0);
    send();

    // straddle pattern: halfword 0 looks long, chains diverge (R3, R4)
    open_block(16'h0001);
    hw[0] = 16'hffff;
    put32(3, 32'h00000013, 2'b00, 0, 0, 21'd0);
    send();

    // random mixes of short and long parcels for the chains
    for (int b = 0; b < 40; b++) begin
      open_block(16'h0001);
      for (int k = 0; k < 17; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        hw[k] = {lfsr[17:4], lfsr[0] | lfsr[3], lfsr[2] | lfsr[5]};
      end
      send();
    end

    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule